// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer

This block schedules conversions for a two-channel converter front end. A mode write selects idle, continuous, single or one of two calibration modes, and may also name the target channel. The sequencer issues a one-cycle start pulse and drives the channel select. It times each conversion itself, from a 7-bit filter word kept per channel: the length is the filter word times 207 clocks. When a conversion ends, the sequencer stores that channel's result and raises that channel's ready bit.

In continuous mode it steps through the enabled channels in ascending order and wraps around, until a new mode is written. A single conversion or a calibration ends in idle. An external sync input can hold back the start of a requested operation. The active-low ready output is combined from the ready bits in one of two ways: it can flag any unread channel, or it can wait until every enabled channel is unread. A small stub stands in for the filter and supplies a running sequence number as each result.

Top module: `conv_sequencer`

## Requirements
- R1: A cycle with mode_we_i high clears every ready bit, so rdy_no is high in the next cycle. It cancels any conversion in progress without storing a result, and it loads the new mode. Mode codes on mode_i are 0 idle, 1 continuous, 2 single, 3 zero-scale calibration and 4 full-scale calibration; any other code is taken as idle.
- R2: Single and calibration operations use the channel given by mode_addr_i[1]. Continuous mode starts at the lowest-numbered enabled channel.
- R3: A channel's ready bit is set exactly max(FW,1)*207 cycles after the cycle in which conv_start_o is high. FW for channel c is fw_i[7c+6:7c].
- R4: conv_start_o is a one-cycle pulse at the start of each conversion or calibration. conv_ch_o names the channel being converted.
- R5: In continuous mode, each completion stores the result and sets that channel's ready bit, and a new conversion starts in the same cycle. The new conversion uses the next enabled channel in ascending order with wrap-around. Disabled channels are skipped, and a lone enabled channel is repeated.
- R6: Continuous conversion keeps going until a mode write.
- R7: With rdy_all_i=0, rdy_no is low whenever any ready bit is set. With rdy_all_i=1, rdy_no is low only when at least one channel is enabled and every enabled channel's ready bit is set.
- R8: When a calibration completes, all ready bits are set, mode_o returns to 0 and the block goes idle. No data register changes.
- R9: While sync_en_i=1 and sync_i=0, a requested operation does not start. conv_start_o rises in the cycle after sync_i is seen high.
- R10: After a single conversion completes, mode_o reads 0 and no further conversion starts.
- R11: rd_ack_i[c] clears ready bit c in the next cycle. If a completion on channel c falls in the same cycle, the bit stays set.
- R12: Each completed conversion stores a sequence number in ch_data_o[24c+23:24c]. The number starts at 1 after reset and increases by one per completed conversion; calibrations and aborted conversions do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode write strobe |
| mode_addr_i | input | 2 | Write address; bit 1 selects the channel |
| mode_i | input | 3 | Mode code |
| ch_en_i | input | 2 | Per-channel enable for continuous mode |
| fw_i | input | 14 | Filter words, 7 bits per channel |
| rdy_all_i | input | 1 | Ready output policy: 0 any unread, 1 all enabled unread |
| sync_en_i | input | 1 | Enables gating by sync_i |
| sync_i | input | 1 | External sync; low holds back starts |
| rd_ack_i | input | 2 | Per-channel data read pulse |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_ch_o | output | 1 | Channel under conversion |
| mode_o | output | 3 | Current mode code |
| rdy_bits_o | output | 2 | Per-channel ready bits |
| rdy_no | output | 1 | Ready output, active low |
| ch_data_o | output | 48 | Per-channel stored results |

## Verification
A completion can land in the same cycle as a read acknowledge on the same channel, or in the same cycle as a mode write. The bench creates both collisions. It counts 206 cycles from the observed start pulse and drives the acknowledge, or the write, on the last cycle of the conversion. In the first case the ready bit must stay set, because the new result wins. In the second case the ready bits must be clear, the data must be unchanged and no further start may follow, because the write wins.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    MD_IDLE   = 3'd0,
    MD_CONT   = 3'd1,
    MD_SINGLE = 3'd2,
    MD_ZCAL   = 3'd3,
    MD_FCAL   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN
  } state_e;

  function automatic mode_e decode_mode(input logic [2:0] code);
    return (code <= 3'd4) ? mode_e'(code) : MD_IDLE;
  endfunction
endpackage

// File: rtl/conv_ch_pick.sv
// Next enabled channel after cur_i, ascending with wrap (cur_i itself is tried last).
module conv_ch_pick #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [CH_W-1:0]   cur_i,
  output logic [CH_W-1:0]   nxt_o,
  output logic              found_o
);
  always_comb begin
    nxt_o   = cur_i;
    found_o = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(cur_i) + k) % NUM_CH;
      if (!found_o && en_i[CH_W'(idx)]) begin
        found_o = 1'b1;
        nxt_o   = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int FW_W  = 7,
  parameter int TICKS = 207,
  localparam int CNT_W = $clog2(((1 << FW_W) - 1) * TICKS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic [FW_W-1:0] fw_i,
  output logic            expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target_w;
  logic [FW_W-1:0]  fw_eff_w;

  assign fw_eff_w = (fw_i == '0) ? FW_W'(1) : fw_i;
  assign target_w = CNT_W'(fw_eff_w) * CNT_W'(TICKS);
  assign expire_o = run_i && (cnt_q == target_w - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/conv_result_stub.sv
// Stand-in for the filter: result is a running sequence number.
module conv_result_stub #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seq_q <= DATA_W'(1);
    else if (capture_i) seq_q <= seq_q + DATA_W'(1);
  end

  assign result_o = seq_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int FW_W   = 7,
  parameter int DATA_W = 24,
  parameter int TICKS  = 207,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_we_i,
  input  logic [CH_W:0]            mode_addr_i,
  input  logic [2:0]               mode_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH*FW_W-1:0]   fw_i,
  input  logic                     rdy_all_i,
  input  logic                     sync_en_i,
  input  logic                     sync_i,
  input  logic [NUM_CH-1:0]        rd_ack_i,
  output logic                     conv_start_o,
  output logic [CH_W-1:0]          conv_ch_o,
  output logic [2:0]               mode_o,
  output logic [NUM_CH-1:0]        rdy_bits_o,
  output logic                     rdy_no,
  output logic [NUM_CH*DATA_W-1:0] ch_data_o
);
  state_e                         state_q;
  mode_e                          mode_q, new_mode_w;
  logic [CH_W-1:0]                ch_q, first_ch_w, next_ch_w, wr_ch_w;
  logic                           first_any_w, next_any_w;
  logic                           start_q;
  logic [NUM_CH-1:0]              rdy_q, rdy_set_w;
  logic [NUM_CH-1:0][DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]              result_w;
  logic [FW_W-1:0]                fw_cur_w;
  logic                           expire_w, done_w, go_w, restart_w;
  logic                           is_cal_w, is_single_w, is_cont_w, st_wait_w;
  logic                           any_rdy_w, all_rdy_w;
  logic                           unused_addr_w;

  assign unused_addr_w = mode_addr_i[0];
  assign new_mode_w    = decode_mode(mode_i);
  assign wr_ch_w       = mode_addr_i[CH_W:1];

  assign is_cal_w    = (mode_q == MD_ZCAL) || (mode_q == MD_FCAL);
  assign is_single_w = (mode_q == MD_SINGLE);
  assign is_cont_w   = (mode_q == MD_CONT);
  assign st_wait_w   = (state_q == ST_WAIT);

  conv_ch_pick #(.NUM_CH(NUM_CH)) u_first (
    .en_i(ch_en_i), .cur_i(CH_W'(NUM_CH - 1)), .nxt_o(first_ch_w), .found_o(first_any_w)
  );
  conv_ch_pick #(.NUM_CH(NUM_CH)) u_next (
    .en_i(ch_en_i), .cur_i(ch_q), .nxt_o(next_ch_w), .found_o(next_any_w)
  );

  assign fw_cur_w = fw_i[ch_q*FW_W +: FW_W];
  assign go_w     = st_wait_w && (!sync_en_i || sync_i) && (!is_cont_w || first_any_w);
  assign done_w   = (state_q == ST_RUN) && expire_w;
  assign restart_w = go_w || (done_w && is_cont_w && next_any_w);

  conv_timer #(.FW_W(FW_W), .TICKS(TICKS)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart_w), .run_i(state_q == ST_RUN),
    .fw_i(fw_cur_w), .expire_o(expire_w)
  );

  conv_result_stub #(.DATA_W(DATA_W)) u_stub (
    .clk_i, .rst_ni, .capture_i(done_w && !is_cal_w && !mode_we_i), .result_o(result_w)
  );

  always_comb begin
    rdy_set_w = '0;
    if (done_w) begin
      if (is_cal_w) rdy_set_w = '1;
      else          rdy_set_w[ch_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_IDLE;
      ch_q    <= '0;
      start_q <= 1'b0;
      rdy_q   <= '0;
      data_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (mode_we_i) begin
        // write aborts everything and wins over a same-cycle completion
        mode_q  <= new_mode_w;
        ch_q    <= wr_ch_w;
        rdy_q   <= '0;
        state_q <= (new_mode_w == MD_IDLE) ? ST_IDLE : ST_WAIT;
      end else begin
        rdy_q <= (rdy_q & ~rd_ack_i) | rdy_set_w;
        unique case (state_q)
          ST_WAIT: if (go_w) begin
            state_q <= ST_RUN;
            start_q <= 1'b1;
            if (is_cont_w) ch_q <= first_ch_w;
          end
          ST_RUN: if (done_w) begin
            if (!is_cal_w) data_q[ch_q] <= result_w;
            if (is_cont_w) begin
              if (next_any_w) begin
                ch_q    <= next_ch_w;
                start_q <= 1'b1;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              mode_q  <= MD_IDLE;
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign any_rdy_w = |rdy_q;
  assign all_rdy_w = (|ch_en_i) && ((rdy_q | ~ch_en_i) == '1);

  assign conv_start_o = start_q;
  assign conv_ch_o    = ch_q;
  assign mode_o       = mode_q;
  assign rdy_bits_o   = rdy_q;
  assign rdy_no       = rdy_all_i ? !all_rdy_w : !any_rdy_w;
  assign ch_data_o    = data_q;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic              sync_en_i,
  input logic              sync_i,
  input logic              conv_start_o,
  input logic [2:0]        mode_o,
  input logic [NUM_CH-1:0] rdy_bits_o,
  input logic              rdy_no,
  input logic              wait_w,
  input logic              done_w,
  input logic              cal_w,
  input logic              single_w
);
  p_write_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (rdy_bits_o == '0) && rdy_no);

  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_sync_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_w && sync_en_i && !sync_i && !mode_we_i) |=> !conv_start_o);

  p_cal_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_w && cal_w && !mode_we_i) |=> (rdy_bits_o == '1) && (mode_o == 3'd0) && !conv_start_o);

  p_single_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_w && single_w && !mode_we_i) |=> (mode_o == 3'd0) && !conv_start_o);

  p_low_needs_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |-> (rdy_bits_o != '0));
endmodule

bind conv_sequencer conv_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .sync_en_i(sync_en_i),
  .sync_i(sync_i), .conv_start_o(conv_start_o), .mode_o(mode_o),
  .rdy_bits_o(rdy_bits_o), .rdy_no(rdy_no), .wait_w(st_wait_w), .done_w(done_w),
  .cal_w(is_cal_w), .single_w(is_single_w)
);

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_addr = '0;
  logic [2:0]  mode = '0;
  logic [1:0]  ch_en = '0;
  logic [13:0] fw = '0;
  logic        rdy_all = 1'b0;
  logic        sync_en = 1'b0;
  logic        sync = 1'b0;
  logic [1:0]  rd_ack = '0;
  logic        conv_start;
  logic [0:0]  conv_ch;
  logic [2:0]  mode_rd;
  logic [1:0]  rdy_bits;
  logic        rdy_n;
  logic [47:0] ch_data;

  int total = 0, bad = 0, cyc = 0, exp_seq = 1;
  bit done = 0;

  always #10 clk = ~clk;

  conv_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_addr_i(mode_addr),
    .mode_i(mode), .ch_en_i(ch_en), .fw_i(fw), .rdy_all_i(rdy_all),
    .sync_en_i(sync_en), .sync_i(sync), .rd_ack_i(rd_ack),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch), .mode_o(mode_rd),
    .rdy_bits_o(rdy_bits), .rdy_no(rdy_n), .ch_data_o(ch_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int data_of(input int c);
    return int'(ch_data[c*24 +: 24]);
  endfunction

  task automatic write_mode(input int c, input int md);
    mode_we = 1'b1; mode_addr = {c[0], 1'b0}; mode = md[2:0];
    step();
    mode_we = 1'b0;
  endtask

  task automatic wait_start(input string tag);
    int i;
    for (i = 0; i < 3000; i++) begin
      step();
      if (conv_start) break;
    end
    chk(conv_start, {tag, " start seen"}, int'(conv_start), 1);
  endtask

  task automatic count_to_rdy(input int c, output int n);
    n = 0;
    for (int i = 1; i <= 3000; i++) begin
      step();
      if (rdy_bits[c]) begin n = i; break; end
    end
  endtask

  task automatic no_start_for(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (conv_start) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset;
    chk(rdy_bits == 2'b00, "R1 reset ready bits", rdy_bits, 0);
    chk(rdy_n == 1'b1, "R7 reset rdy_no", rdy_n, 1);
    chk(mode_rd == 3'd0 && !conv_start, "R10 reset mode idle", mode_rd, 0);
    chk(ch_data == '0, "R12 reset data", data_of(0), 0);
  endtask

  task automatic t_single;
    int n;
    fw = {7'd1, 7'd1}; rdy_all = 1'b0;
    write_mode(1, 2);
    wait_start("R4 single");
    chk(conv_ch == 1'b1, "R2 single channel from addr bit1", conv_ch, 1);
    count_to_rdy(1, n);
    chk(n == 207, "R3 single duration", n, 207);
    chk(data_of(1) == exp_seq, "R12 single data", data_of(1), exp_seq);
    exp_seq++;
    chk(mode_rd == 3'd0, "R10 mode idle after single", mode_rd, 0);
    chk(rdy_n == 1'b0, "R7 any unread low", rdy_n, 0);
    no_start_for(400, "R10 no restart after single");
  endtask

  task automatic t_read;
    rd_ack = 2'b10; step(); rd_ack = 2'b00;
    chk(rdy_bits == 2'b00, "R11 read clears bit", rdy_bits, 0);
    chk(rdy_n == 1'b1, "R11 rdy_no high after read", rdy_n, 1);
  endtask

  task automatic t_cont;
    int n; int d0;
    ch_en = 2'b11; fw = {7'd2, 7'd1}; rdy_all = 1'b1;
    write_mode(1, 1);
    wait_start("R5 cont");
    chk(conv_ch == 1'b0, "R2 cont starts lowest enabled", conv_ch, 0);
    count_to_rdy(0, n);
    chk(n == 207, "R3 ch0 fw=1 duration", n, 207);
    chk(rdy_n == 1'b1, "R7 all-mode high with one unread", rdy_n, 1);
    chk(conv_start && conv_ch == 1'b1, "R5 next start on ch1", conv_ch, 1);
    count_to_rdy(1, n);
    chk(n == 414, "R3 ch1 fw=2 duration", n, 414);
    chk(rdy_n == 1'b0, "R7 all-mode low when all unread", rdy_n, 0);
    chk(data_of(0) == exp_seq, "R12 ch0 data", data_of(0), exp_seq);
    chk(data_of(1) == exp_seq + 1, "R12 ch1 data", data_of(1), exp_seq + 1);
    exp_seq += 2;
    chk(conv_start && conv_ch == 1'b0, "R6 wraps back to ch0", conv_ch, 0);
    d0 = data_of(0);
    step(100);
    write_mode(0, 0);
    chk(rdy_bits == 2'b00 && rdy_n, "R1 write idle clears ready", rdy_bits, 0);
    chk(mode_rd == 3'd0, "R1 mode now idle", mode_rd, 0);
    no_start_for(500, "R6 stops after mode write");
    chk(data_of(0) == d0, "R1 aborted conversion stores nothing", data_of(0), d0);
    rdy_all = 1'b0;
  endtask

  task automatic t_skip;
    int n;
    ch_en = 2'b10;
    write_mode(0, 1);
    wait_start("R5 skip");
    chk(conv_ch == 1'b1, "R5 disabled ch0 skipped", conv_ch, 1);
    count_to_rdy(1, n);
    chk(n == 414, "R3 ch1 duration", n, 414);
    chk(conv_start && conv_ch == 1'b1, "R5 lone channel repeats", conv_ch, 1);
    exp_seq++;
    write_mode(0, 0);
  endtask

  task automatic t_cal;
    int n; int d0, d1;
    ch_en = 2'b11; d0 = data_of(0); d1 = data_of(1);
    write_mode(0, 3);
    wait_start("R8 zcal");
    chk(conv_ch == 1'b0, "R2 cal channel ch0", conv_ch, 0);
    count_to_rdy(0, n);
    chk(n == 207, "R3 cal duration", n, 207);
    chk(rdy_bits == 2'b11, "R8 cal sets all ready", rdy_bits, 3);
    chk(mode_rd == 3'd0 && rdy_n == 1'b0, "R8 cal ends idle", mode_rd, 0);
    chk(data_of(0) == d0 && data_of(1) == d1, "R8 cal leaves data", data_of(0), d0);
    write_mode(1, 4);
    wait_start("R8 fcal");
    chk(conv_ch == 1'b1, "R2 fcal channel ch1", conv_ch, 1);
    count_to_rdy(1, n);
    chk(n == 414, "R3 fcal duration", n, 414);
    chk(rdy_bits == 2'b11 && mode_rd == 3'd0, "R8 fcal ready all", rdy_bits, 3);
    no_start_for(300, "R8 idle after cal");
  endtask

  task automatic t_sync;
    int n;
    sync_en = 1'b1; sync = 1'b0;
    write_mode(0, 2);
    no_start_for(60, "R9 held while sync low");
    sync = 1'b1; step();
    chk(conv_start == 1'b1, "R9 start cycle after sync high", conv_start, 1);
    count_to_rdy(0, n);
    chk(n == 207, "R9 duration after sync", n, 207);
    chk(data_of(0) == exp_seq, "R12 data after sync", data_of(0), exp_seq);
    exp_seq++;
    sync_en = 1'b0;
  endtask

  task automatic t_collide_ack;
    write_mode(0, 2);
    wait_start("R11 collide");
    step(206);
    rd_ack = 2'b01; step(); rd_ack = 2'b00;
    chk(rdy_bits[0] == 1'b1, "R11 completion beats same-cycle read", rdy_bits[0], 1);
    chk(data_of(0) == exp_seq, "R12 data on collide", data_of(0), exp_seq);
    exp_seq++;
  endtask

  task automatic t_collide_write;
    int d0;
    ch_en = 2'b01; d0 = data_of(0);
    write_mode(0, 1);
    wait_start("R1 collide");
    step(206);
    write_mode(0, 0);
    chk(rdy_bits == 2'b00, "R1 write beats same-cycle completion", rdy_bits, 0);
    chk(data_of(0) == d0, "R1 no data on aborted completion", data_of(0), d0);
    no_start_for(300, "R1 no start after abort");
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_read();
    t_cont();
    t_skip();
    t_cal();
    t_sync();
    t_collide_ack();
    t_collide_write();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule